// File: doc/BRIEF.md
# Bitmap-mode CHR address remapper

This block sits on the path from the picture processor's address bus to an 8 KiB pattern RAM. In normal mode it forwards the low thirteen address bits unchanged. In bitmap mode it swaps two of those bits during pattern-table fetches. Pattern line 3 is driven from address bit 0 and pattern line 12 from address bit 9. Both values are taken from the address that was present when address bit 13 last went from 0 to 1. That rising edge marks the nametable fetch, and the pattern fetch that follows reuses the column and row information it carried. With this remapping the 8 KiB RAM can hold a full-screen, all-points-addressable bitmap.

Address bit 13 is sampled with the system clock to find its rising edge, and the two captured bits are held in a small latch. The remapped address leaves the block through a register, so it is ready one clock after the input address. A single control input chooses the mode. It is expected to come from a mapper register that clears on reset.

Top module: `bitmap_chr_remap`

## Requirements
- R1: With `bitmap_en`=0 and `ppu_addr[13]`=0, `chr_addr[3]` equals `ppu_addr[3]` and `chr_addr[12]` equals `ppu_addr[12]`.
- R2: With `bitmap_en`=1 and `ppu_addr[13]`=0, `chr_addr[3]` equals the captured copy of `ppu_addr[0]` and `chr_addr[12]` equals the captured copy of `ppu_addr[9]`.
- R3: The captured copies are updated only in a cycle where `ppu_addr[13]` is 1 and was 0 in the previous cycle (after reset the previous value counts as 0). Cycles that keep `ppu_addr[13]` high do not update them.
- R4: With `ppu_addr[13]`=1, `chr_addr[3]` and `chr_addr[12]` equal `ppu_addr[3]` and `ppu_addr[12]`, whatever the value of `bitmap_en`.
- R5: `chr_addr` bits other than 3 and 12 always equal the same bits of `ppu_addr`.
- R6: During reset `chr_addr` is 0 and both captured copies clear to 0.
- R7: `chr_addr` is registered and reflects the inputs that were present at the previous rising clock edge.
- R8: While `ppu_addr[13]` stays 0, changes on `ppu_addr[0]` and `ppu_addr[9]` do not change the captured copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bitmap_en | input | 1 | 1 selects bitmap remapping |
| ppu_addr | input | 14 | Picture processor address bits 13..0 |
| chr_addr | output | 13 | Registered pattern RAM address |

## Verification
Every result appears exactly one clock after its input address. Captured bits take effect starting with the first address presented after the rising-edge cycle. The bench changes inputs on the falling clock edge and reads `chr_addr` just after the next rising edge. A model in the bench is advanced once per applied address, with the same one-edge delay. Sequences of a nametable fetch, a held-high cycle and several pattern fetches are swept across all 16 combinations of the source and pass-through bits, in both modes.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  // Bits captured at the nametable edge, held for the pattern fetch
  typedef struct packed {
    logic hi;  // copy of the row-select source bit
    logic lo;  // copy of the column-select source bit
  } bmr_latch_t;
endpackage

// File: rtl/bmr_edge.sv
module bmr_edge (
  input  logic clk,
  input  logic rst,
  input  logic sel_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel_in;
  end

  assign rise = sel_in & ~prev_q;

  // R3
  rise_once_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/bmr_capture.sv
module bmr_capture
  import bmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rise,
  input  logic       lo_in,
  input  logic       hi_in,
  output bmr_latch_t held
);
  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (rise) begin
      held.lo <= lo_in;
      held.hi <= hi_in;
    end
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (held.lo == $past(lo_in)) && (held.hi == $past(hi_in)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(held));
endmodule

// File: rtl/bmr_mux.sv
module bmr_mux
  import bmr_pkg::*;
#(
  parameter int CHR_W   = 13,
  parameter int REPL_LO = 3,
  parameter int REPL_HI = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitmap_en,
  input  logic             nt_sel,
  input  logic [CHR_W-1:0] addr_in,
  input  bmr_latch_t       held,
  output logic [CHR_W-1:0] chr_q
);
  logic             remap;
  logic [CHR_W-1:0] next_addr;

  assign remap = bitmap_en & ~nt_sel;

  for (genvar b = 0; b < CHR_W; b++) begin : g_bit
    if (b == REPL_LO) begin : g_lo
      assign next_addr[b] = remap ? held.lo : addr_in[b];
    end else if (b == REPL_HI) begin : g_hi
      assign next_addr[b] = remap ? held.hi : addr_in[b];
    end else begin : g_pass
      assign next_addr[b] = addr_in[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chr_q <= '0;
    else     chr_q <= next_addr;
  end

  // R4
  nt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    nt_sel |=> (chr_q[REPL_LO] == $past(addr_in[REPL_LO])) &&
               (chr_q[REPL_HI] == $past(addr_in[REPL_HI])));
  // R1
  normal_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!bitmap_en && !nt_sel) |=> (chr_q[REPL_LO] == $past(addr_in[REPL_LO])) &&
                                (chr_q[REPL_HI] == $past(addr_in[REPL_HI])));
  // R2
  bitmap_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (bitmap_en && !nt_sel) |=> (chr_q[REPL_LO] == $past(held.lo)) &&
                               (chr_q[REPL_HI] == $past(held.hi)));
  // R5
  other_bits_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((chr_q ^ $past(addr_in)) &
              ~((CHR_W)'(1) << REPL_LO) & ~((CHR_W)'(1) << REPL_HI)) == '0);
endmodule

// File: rtl/bitmap_chr_remap.sv
module bitmap_chr_remap
  import bmr_pkg::*;
#(
  parameter int PPU_W   = 14,
  parameter int SRC_LO  = 0,
  parameter int SRC_HI  = 9,
  parameter int REPL_LO = 3,
  parameter int REPL_HI = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitmap_en,
  input  logic [PPU_W-1:0] ppu_addr,
  output logic [PPU_W-2:0] chr_addr
);
  localparam int CHR_W  = PPU_W - 1;
  localparam int NT_BIT = PPU_W - 1;

  logic       nt_rise;
  bmr_latch_t held;

  bmr_edge i_edge (
    .clk    (clk),
    .rst    (rst),
    .sel_in (ppu_addr[NT_BIT]),
    .rise   (nt_rise)
  );

  bmr_capture i_capture (
    .clk   (clk),
    .rst   (rst),
    .rise  (nt_rise),
    .lo_in (ppu_addr[SRC_LO]),
    .hi_in (ppu_addr[SRC_HI]),
    .held  (held)
  );

  bmr_mux #(
    .CHR_W   (CHR_W),
    .REPL_LO (REPL_LO),
    .REPL_HI (REPL_HI)
  ) i_mux (
    .clk       (clk),
    .rst       (rst),
    .bitmap_en (bitmap_en),
    .nt_sel    (ppu_addr[NT_BIT]),
    .addr_in   (ppu_addr[CHR_W-1:0]),
    .held      (held),
    .chr_q     (chr_addr)
  );

  // R6
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (chr_addr == '0) && (held == '0));
endmodule

// File: tb/test_bitmap_chr_remap.sv
module test_bitmap_chr_remap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitmap_en = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [12:0] chr_addr;

  int errors = 0;
  int checks = 0;
  logic m_prev = 1'b0, m_lo = 1'b0, m_hi = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  bitmap_chr_remap i_bitmap_chr_remap (
    .clk       (clk),
    .rst       (rst),
    .bitmap_en (bitmap_en),
    .ppu_addr  (ppu_addr),
    .chr_addr  (chr_addr)
  );

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R7: drive at the falling edge, sample 1 ns after the next rising edge
  task automatic apply(input logic en, input logic [13:0] a, input string tag);
    logic [12:0] exp;
    logic [12:0] mask;
    @(negedge clk);
    bitmap_en = en;
    ppu_addr  = a;
    exp = a[12:0];
    if (en && !a[13]) begin
      exp[3]  = m_lo;
      exp[12] = m_hi;
    end
    if (a[13] && !m_prev) begin
      m_lo = a[0];
      m_hi = a[9];
    end
    m_prev = a[13];
    @(posedge clk);
    #1;
    mask = 13'h1008;
    check(tag, chr_addr & mask, exp & mask);
    check("R5", chr_addr & ~mask, exp & ~mask);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ppu_addr = 14'h1FFF;
    repeat (3) @(posedge clk);
    #1;
    check("R6", chr_addr, 13'h0000);
    @(negedge clk);
    rst = 1'b0;
    // R6: cleared capture seen by a pattern fetch before any rising edge
    apply(1'b1, 14'h1209, "R6");
    for (int en = 0; en < 2; en++) begin
      for (int k = 0; k < 16; k++) begin
        logic [13:0] nt, pt;
        nt = 14'h2000 | 14'(k[0]) | (14'(k[1]) << 9) | (14'(k[2]) << 3)
           | (14'(k[3]) << 12) | 14'h0440;
        apply(en[0], nt, "R4");
        // still high: R3 says no recapture
        apply(en[0], nt ^ 14'h0201, "R3");
        pt = 14'h0A52 ^ (14'(k) << 2);
        apply(en[0], pt, en ? "R2" : "R1");
        // R8: source bits toggle while the pattern fetch continues
        apply(en[0], pt ^ 14'h0201, en ? "R8" : "R1");
        apply(en[0], pt ^ 14'h1008, en ? "R8" : "R1");
      end
    end
    // R4: bitmap on, nametable space passes bits 3 and 12
    apply(1'b1, 14'h3008, "R4");
    apply(1'b1, 14'h3FFF, "R4");
    apply(1'b1, 14'h0000, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule